// File: doc/BRIEF.md
# Occupancy-Based Fetch Thread Selector with Address-Watch Sleep

This block decides, every cycle, which hardware thread the shared front end of a simultaneous multithreaded core fetches from. It keeps one in-flight instruction count per thread. The count rises when the thread is granted fetch and falls when the thread's instructions retire or are squashed. Among the threads allowed to fetch, the one holding the fewest in-flight instructions wins. A rotating pointer settles ties.

A spinning thread can step aside. It first arms a watch on an address and then issues a sleep command. From then on it is left out of selection until a snooped store hits the watched address. Each thread's share of the instruction window is capped. The cap is half the window while two or more threads are awake, and the full window otherwise. The selection output is combinational from registered state. A grant is taken as a fetch, so the granted thread's count rises at the next clock edge.

Top module: `fetch_pick`

## Requirements
- R1: Right after reset, all counts are zero, no thread sleeps and no watch is armed. The tie pointer is 0, so `fetch_valid`=1 and `fetch_tid`=0.
- R2: The grant goes to the eligible thread with the smallest in-flight count. A thread is eligible when it is not sleeping and its count is below the cap.
- R3: Among eligible threads that share the smallest count, the grant goes to the first thread at or after the tie pointer, in ascending order with wraparound. After each grant the pointer moves to one past the granted thread.
- R4: A thread's count changes at each clock edge by +1 if granted that cycle, -1 if `retire_i[t]` is high and -1 if `squash_i[t]` is high. The result saturates at zero.
- R5: With two or more threads awake, the cap is WIN/2 (16 by default). With at most one thread awake, the cap is WIN (32).
- R6: A sleep command (`quiesce_valid`, `quiesce_tid`) for a thread with an armed watch removes that thread from selection until a matching snoop arrives. Retires on the sleeping thread still lower its count.
- R7: A snoop (`snoop_valid`, `snoop_addr`) equal to a thread's armed watch address wakes that thread and disarms its watch, for every thread watching that address at once. A snoop that matches no armed address has no effect.
- R8: A sleep command for a thread with no armed watch excludes it for exactly the next cycle only.
- R9: When no thread is eligible, `fetch_valid`=0 and no count is incremented.
- R10: An arm command (`arm_valid`, `arm_tid`, `arm_addr`) replaces any earlier watch address of that thread. Only the newest address wakes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | NTHR | One retire per flagged thread this cycle |
| squash_i | input | NTHR | One squashed instruction per flagged thread this cycle |
| arm_valid | input | 1 | Arm a watch for `arm_tid` |
| arm_tid | input | $clog2(NTHR) | Thread that arms |
| arm_addr | input | ADDR_W | Address to watch |
| quiesce_valid | input | 1 | Put `quiesce_tid` to sleep |
| quiesce_tid | input | $clog2(NTHR) | Thread that sleeps |
| snoop_valid | input | 1 | A store address is observed |
| snoop_addr | input | ADDR_W | Observed store address |
| fetch_valid | output | 1 | A thread is granted fetch this cycle |
| fetch_tid | output | $clog2(NTHR) | Granted thread |

## Verification
The hardest state to reach from the ports is the full-window cap. To get there, every thread except one must be asleep behind an armed watch while the remaining thread sits exactly at the half-window cap. The stimulus first lets round-robin grants fill every thread to 16 with no retires. It then arms and puts three threads to sleep one by one. Finally it confirms that the last awake thread resumes fetching up to 32. From that saturated state, selective retires on sleeping threads, a non-matching snoop, a shared-address snoop and a re-armed address show which threads wake and in what order.

// File: rtl/fetch_pick.sv
module fetch_pick #(
  parameter int NTHR   = 4,
  parameter int WIN    = 32,
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NTHR-1:0]           retire_i,
  input  logic [NTHR-1:0]           squash_i,
  input  logic                      arm_valid,
  input  logic [$clog2(NTHR)-1:0]   arm_tid,
  input  logic [ADDR_W-1:0]         arm_addr,
  input  logic                      quiesce_valid,
  input  logic [$clog2(NTHR)-1:0]   quiesce_tid,
  input  logic                      snoop_valid,
  input  logic [ADDR_W-1:0]         snoop_addr,
  output logic                      fetch_valid,
  output logic [$clog2(NTHR)-1:0]   fetch_tid
);
  localparam int TID_W = $clog2(NTHR);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int HALF  = WIN / 2;

  logic [NTHR-1:0][CNT_W-1:0]  cnt_q;
  logic [NTHR-1:0][ADDR_W-1:0] watch_q;
  logic [NTHR-1:0]             quies_q, armed_q;
  logic [TID_W-1:0]            ptr_q;
  logic [CNT_W-1:0]            cap, best;
  logic                        sel_ok;
  logic [TID_W-1:0]            sel_tid;

  assign cap = ($countones(~quies_q) >= 2) ? CNT_W'(HALF) : CNT_W'(WIN);

  always_comb begin
    sel_ok  = 1'b0;
    sel_tid = '0;
    best    = '0;
    for (int i = 0; i < NTHR; i++) begin
      int k;
      k = int'(ptr_q) + i;
      if (k >= NTHR) k = k - NTHR;
      if (!quies_q[k] && cnt_q[k] < cap && (!sel_ok || cnt_q[k] < best)) begin
        sel_ok  = 1'b1;
        sel_tid = TID_W'(k);
        best    = cnt_q[k];
      end
    end
  end

  assign fetch_valid = sel_ok;
  assign fetch_tid   = sel_tid;

  always_ff @(posedge clk) begin
    if (!rst_n)           ptr_q <= '0;
    else if (fetch_valid) ptr_q <= (int'(fetch_tid) == NTHR - 1) ? '0 : fetch_tid + 1'b1;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic             inc, hit, arm_me, slp_me;
    logic [1:0]       dec;
    logic [CNT_W:0]   up;

    assign inc    = fetch_valid && fetch_tid == TID_W'(t);
    assign dec    = {1'b0, retire_i[t]} + {1'b0, squash_i[t]};
    assign up     = {1'b0, cnt_q[t]} + {{CNT_W{1'b0}}, inc};
    assign hit    = snoop_valid && armed_q[t] && watch_q[t] == snoop_addr;
    assign arm_me = arm_valid && arm_tid == TID_W'(t);
    assign slp_me = quiesce_valid && quiesce_tid == TID_W'(t);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[t]   <= '0;
        quies_q[t] <= 1'b0;
        armed_q[t] <= 1'b0;
        watch_q[t] <= '0;
      end else begin
        cnt_q[t] <= (up > (CNT_W+1)'(dec)) ? CNT_W'(up - (CNT_W+1)'(dec)) : '0;
        if (arm_me) begin
          armed_q[t] <= 1'b1;
          watch_q[t] <= arm_addr;
        end else if (hit) begin
          armed_q[t] <= 1'b0;
        end
        if (hit)               quies_q[t] <= 1'b0;
        else if (slp_me)       quies_q[t] <= 1'b1;
        else if (!armed_q[t])  quies_q[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetch_pick_chk.sv
module fetch_pick_chk #(
  parameter int NTHR   = 4,
  parameter int WIN    = 32,
  parameter int ADDR_W = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NTHR-1:0]                   retire_i,
  input logic [NTHR-1:0]                   squash_i,
  input logic                              arm_valid,
  input logic [$clog2(NTHR)-1:0]           arm_tid,
  input logic [ADDR_W-1:0]                 arm_addr,
  input logic                              quiesce_valid,
  input logic [$clog2(NTHR)-1:0]           quiesce_tid,
  input logic                              snoop_valid,
  input logic [ADDR_W-1:0]                 snoop_addr,
  input logic                              fetch_valid,
  input logic [$clog2(NTHR)-1:0]           fetch_tid,
  input logic [NTHR-1:0][$clog2(WIN+1)-1:0] cnt_q,
  input logic [NTHR-1:0]                   quies_q,
  input logic [NTHR-1:0]                   armed_q,
  input logic [NTHR-1:0][ADDR_W-1:0]       watch_q
);
  localparam int TID_W = $clog2(NTHR);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int HALF  = WIN / 2;

  assert_sleeper_skipped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !quies_q[fetch_tid]);

  assert_half_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $countones(~quies_q) >= 2) |-> cnt_q[fetch_tid] < CNT_W'(HALF));

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[t] <= CNT_W'(WIN));

    assert_grant_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_tid == TID_W'(t) && !retire_i[t] && !squash_i[t])
      |=> cnt_q[t] == $past(cnt_q[t]) + 1'b1);

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !retire_i[t] && !squash_i[t]) |=> $stable(cnt_q[t]));

    assert_snoop_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && armed_q[t] && watch_q[t] == snoop_addr &&
       !(arm_valid && arm_tid == TID_W'(t))) |=> (!quies_q[t] && !armed_q[t]));

    assert_unarmed_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (quies_q[t] && !armed_q[t] && !(quiesce_valid && quiesce_tid == TID_W'(t)) &&
       !(arm_valid && arm_tid == TID_W'(t))) |=> !quies_q[t]);

    assert_arm_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_valid && arm_tid == TID_W'(t)) |=> (armed_q[t] && watch_q[t] == $past(arm_addr)));
  end
endmodule

bind fetch_pick fetch_pick_chk #(.NTHR(NTHR), .WIN(WIN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .squash_i(squash_i),
  .arm_valid(arm_valid), .arm_tid(arm_tid), .arm_addr(arm_addr),
  .quiesce_valid(quiesce_valid), .quiesce_tid(quiesce_tid),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
  .cnt_q(cnt_q), .quies_q(quies_q), .armed_q(armed_q), .watch_q(watch_q)
);

// File: tb/tb_fetch_pick.sv
module tb_fetch_pick;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] retire_i = '0, squash_i = '0;
  logic       arm_valid = 1'b0, quiesce_valid = 1'b0, snoop_valid = 1'b0;
  logic [1:0] arm_tid = '0, quiesce_tid = '0;
  logic [15:0] arm_addr = '0, snoop_addr = '0;
  logic       fetch_valid;
  logic [1:0] fetch_tid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fetch_pick dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .squash_i(squash_i),
    .arm_valid(arm_valid), .arm_tid(arm_tid), .arm_addr(arm_addr),
    .quiesce_valid(quiesce_valid), .quiesce_tid(quiesce_tid),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .fetch_valid(fetch_valid), .fetch_tid(fetch_tid)
  );

  // {expected valid, expected tid, retire[3:0], squash[3:0]}
  localparam logic [10:0] VEC [9] = '{
    {1'b1, 2'd0, 4'b0000, 4'b0000},
    {1'b1, 2'd1, 4'b0000, 4'b0000},
    {1'b1, 2'd2, 4'b0000, 4'b0000},
    {1'b1, 2'd3, 4'b0000, 4'b0000},
    {1'b1, 2'd0, 4'b0100, 4'b0000},
    {1'b1, 2'd2, 4'b0001, 4'b0001},
    {1'b1, 2'd0, 4'b1000, 4'b1000},
    {1'b1, 2'd3, 4'b0000, 4'b0000},
    {1'b1, 2'd0, 4'b0000, 4'b0000}
  };

  task automatic tick();
    @(negedge clk);
    retire_i = '0; squash_i = '0;
    arm_valid = 1'b0; quiesce_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic chk(string req, logic ev, logic [1:0] et);
    checks++;
    if (fetch_valid !== ev || (ev && fetch_tid !== et)) begin
      failures++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, fetch_valid, fetch_tid, ev, et);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic arm(logic [1:0] t, logic [15:0] a);
    arm_valid = 1'b1; arm_tid = t; arm_addr = a; tick();
  endtask

  task automatic sleep(logic [1:0] t);
    quiesce_valid = 1'b1; quiesce_tid = t; tick();
  endtask

  task automatic snoop(logic [15:0] a);
    snoop_valid = 1'b1; snoop_addr = a; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();
    chk("R1 reset grant", 1'b1, 2'd0);

    // R2 R3 R4: least count wins, rotating ties, saturating decrement
    foreach (VEC[i]) begin
      chk($sformatf("R2/R3/R4 vector %0d", i), VEC[i][10], VEC[i][9:8]);
      retire_i = VEC[i][7:4];
      squash_i = VEC[i][3:0];
      tick();
    end

    // R8: sleep without watch lasts one cycle
    do_reset();
    repeat (4) tick();
    chk("R3 rotation back to 0", 1'b1, 2'd0);
    retire_i = 4'b0001; squash_i = 4'b0001;
    quiesce_valid = 1'b1; quiesce_tid = 2'd0;
    tick();
    chk("R8 unarmed sleeper skipped", 1'b1, 2'd1);
    tick();
    chk("R8 unarmed sleeper back", 1'b1, 2'd0);

    // R5 R9: fill every thread to half window
    do_reset();
    repeat (63) tick();
    chk("R5 last slot below half cap", 1'b1, 2'd3);
    tick();
    chk("R9 all at half cap", 1'b0, 2'd0);
    tick();
    chk("R9 idle stays idle", 1'b0, 2'd0);
    retire_i = 4'b0100;
    tick();
    chk("R9 one slot freed on t2", 1'b1, 2'd2);
    tick();
    chk("R9 counts unchanged while idle", 1'b0, 2'd0);

    // R5 R6: three threads sleep behind watches
    arm(2'd1, 16'h1000);
    arm(2'd2, 16'h2000);
    arm(2'd3, 16'h1000);
    sleep(2'd1);
    sleep(2'd2);
    chk("R5 two awake keep half cap", 1'b0, 2'd0);
    sleep(2'd3);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R5 lone thread full window %0d", i), 1'b1, 2'd0);
      tick();
    end
    chk("R5 lone thread at full window", 1'b0, 2'd0);
    retire_i = 4'b1010;
    tick();
    chk("R6 sleeper with room stays out", 1'b0, 2'd0);

    // R7: snoops
    snoop(16'h3000);
    chk("R7 unmatched snoop ignored", 1'b0, 2'd0);
    snoop(16'h1000);
    chk("R7 shared watch wakes t1", 1'b1, 2'd1);
    tick();
    chk("R7 shared watch wakes t3", 1'b1, 2'd3);
    tick();
    chk("R7 other watcher still asleep", 1'b0, 2'd0);

    // R10: re-arm replaces address
    retire_i = 4'b0100; tick();
    retire_i = 4'b0100; tick();
    chk("R6 t2 still asleep after retires", 1'b0, 2'd0);
    arm(2'd2, 16'h4000);
    snoop(16'h2000);
    chk("R10 old address no longer wakes", 1'b0, 2'd0);
    snoop(16'h4000);
    chk("R10 new address wakes", 1'b1, 2'd2);
    tick();
    chk("R10 t2 keeps fetching", 1'b1, 2'd2);
    tick();
    chk("R5 t2 back at half cap", 1'b0, 2'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule